// File: doc/BRIEF.md
# Counter Compare/Capture Channel

This block is one channel of a counter array. A free-running 16-bit count comes in from outside and is shared by every channel. A 7-bit mode word selects what the channel does with that count. It can latch the count when a chosen edge arrives on an external capture pin. It can compare the count against a stored 16-bit value and, on a match, raise an event flag, invert its output pin, or do both. It can also drive the pin as a pulse-width-modulated waveform, using the low byte of the count against the low byte of the stored value.

An interrupt request follows the event flag, gated by an enable bit in the mode word. Software writes the mode word and the stored value through single-cycle strobes. It clears the flag through a third strobe. The block has no data stream, so there is no valid/ready handshake. Every write strobe is taken in the cycle it is asserted and is never back-pressured. The stored value comes out on `cap_val_o` so that software can read it.

The mode word bit positions are fixed, because software builds the word: bit 6 enables the comparator, bit 5 enables rising-edge capture, bit 4 enables falling-edge capture, bit 3 lets a match set the flag, bit 2 lets a match invert the pin, bit 1 selects PWM, and bit 0 enables the interrupt.

Top module: `ccm_channel`

## Requirements
- R1: After reset, the mode word, the stored value, the flag, the pin and the interrupt are all zero.
- R2: With mode bit 5 set, a rising edge on `cap_pin_i` loads `cnt_i` into the stored value and sets the flag. The pin passes through two synchroniser flops, so with the pin changed between clock edges k-1 and k, the load happens at edge k+2 and uses the `cnt_i` present before that edge.
- R3: With mode bit 4 set, a falling edge captures in the same way. With bits 5 and 4 both set, either edge captures, and each edge causes exactly one capture.
- R4: With mode bit 6 clear, the count crossing the stored value never sets the flag and never changes the pin.
- R5: With bits 6 and 3 set, a match sets the flag at the clock edge where the count takes the stored value. With bit 3 clear, a match leaves the flag unchanged.
- R6: With bits 6 and 2 set and bit 1 clear, each match inverts `pin_o` at that same edge.
- R7: A match is seen only on the edge where `cnt_i` differs from its value at the previous edge. A count held at the stored value for many cycles produces one event.
- R8: With bit 1 set, `pin_o` is 0 when the count's low byte at the previous edge was below the stored low byte, and 1 otherwise. Each time the low byte wraps from 0xFF to 0x00, the stored high byte is copied into the stored low byte.
- R9: `irq_o` is 1 exactly when the flag is 1 and mode bit 0 is 1.
- R10: `flag_clr_i` clears the flag. A capture, or a flag-setting match, in the same cycle wins and leaves the flag set.
- R11: `val_we_i` loads `val_wdata_i` into the stored value. A capture in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Shared free-running count |
| cap_pin_i | input | 1 | External capture pin, asynchronous |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_wdata_i | input | 7 | New mode word |
| val_we_i | input | 1 | Stored value write strobe |
| val_wdata_i | input | 16 | New stored value |
| flag_clr_i | input | 1 | Event flag clear strobe |
| pin_o | output | 1 | Toggle or PWM output pin |
| flag_o | output | 1 | Event flag |
| irq_o | output | 1 | Interrupt request |
| cap_val_o | output | 16 | Stored compare/capture value |

## Verification
Captures are tried on a held count with rising, falling and both-edge modes. This tells the three edge selections apart and pins down the two-clock synchroniser delay exactly. Compare runs sweep the count across the stored value under each combination of the comparator, flag and toggle enables. A held count then shows that a stall at the match value gives one event and not many. Same-cycle collisions (clear against match, write against capture) fix the priority order. PWM windows of 256 counts, taken before and after a high-byte change, measure the duty directly and show that the new duty takes effect only after a low-byte wrap.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  // Field order follows the bit positions software writes (bit 6 down to bit 0).
  typedef struct packed {
    logic cmp_en;     // bit 6: comparator enable
    logic cap_rise;   // bit 5: capture on rising edge
    logic cap_fall;   // bit 4: capture on falling edge
    logic flag_en;    // bit 3: match sets the flag
    logic toggle_en;  // bit 2: match inverts the pin
    logic pwm_en;     // bit 1: pin is PWM
    logic irq_en;     // bit 0: interrupt enable
  } ccm_mode_t;

  localparam int MODE_W = $bits(ccm_mode_t);
endpackage

// File: rtl/ccm_edge_detect.sv
module ccm_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q[0] <= pin_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      seen_q <= sync_q[LAST];
    end
  end

  assign rise_o = sync_q[LAST] & ~seen_q;
  assign fall_o = ~sync_q[LAST] & seen_q;

  // One pin edge must yield a single-cycle pulse (R3).
  p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  p_single_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ccm_match.sv
module ccm_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ref_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt_i;
  end

  // Hit only on the edge where the count arrives at the reference (R7).
  assign hit_o = en_i && (cnt_i == ref_i) && (cnt_i != prev_q);
endmodule

// File: rtl/ccm_pwm.sv
module ccm_pwm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] cnt_lo_i,
  input  logic [BYTE_W-1:0] ref_lo_i,
  output logic              wrap_o,
  output logic              out_o
);
  logic [BYTE_W-1:0] prev_lo_q;
  logic              out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lo_q <= '0;
      out_q     <= 1'b0;
    end else begin
      prev_lo_q <= cnt_lo_i;
      out_q     <= en_i && (cnt_lo_i >= ref_lo_i);
    end
  end

  assign wrap_o = en_i && (&prev_lo_q) && (cnt_lo_i == '0);
  assign out_o  = out_q;

  p_pwm_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_lo_i < ref_lo_i) |=> !out_o);
  p_pwm_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_lo_i >= ref_lo_i) |=> out_o);
endmodule

// File: rtl/ccm_channel.sv
module ccm_channel
  import ccm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cap_pin_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              val_we_i,
  input  logic [CNT_W-1:0]  val_wdata_i,
  input  logic              flag_clr_i,
  output logic              pin_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  cap_val_o
);
  localparam int HALF = CNT_W / 2;

  ccm_mode_t        mode_q;
  logic [CNT_W-1:0] val_q;
  logic             flag_q;
  logic             tog_q;

  logic rise, fall, cap_ev, hit, wrap, pwm_out, set_ev;

  ccm_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i),
    .rise_o(rise), .fall_o(fall)
  );

  ccm_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .en_i(mode_q.cmp_en),
    .cnt_i(cnt_i), .ref_i(val_q), .hit_o(hit)
  );

  ccm_pwm #(.BYTE_W(HALF)) u_pwm (
    .clk(clk), .rst_n(rst_n), .en_i(mode_q.pwm_en),
    .cnt_lo_i(cnt_i[HALF-1:0]), .ref_lo_i(val_q[HALF-1:0]),
    .wrap_o(wrap), .out_o(pwm_out)
  );

  assign cap_ev = (rise & mode_q.cap_rise) | (fall & mode_q.cap_fall);
  assign set_ev = cap_ev | (hit & mode_q.flag_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      val_q  <= '0;
      flag_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= ccm_mode_t'(mode_wdata_i);
      // Priority: capture, then software write, then PWM reload.
      if (cap_ev)        val_q <= cnt_i;
      else if (val_we_i) val_q <= val_wdata_i;
      else if (wrap)     val_q[HALF-1:0] <= val_q[CNT_W-1:HALF];
      if (set_ev)          flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (hit && mode_q.toggle_en) tog_q <= ~tog_q;
    end
  end

  assign pin_o     = mode_q.pwm_en ? pwm_out : tog_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & mode_q.irq_en;
  assign cap_val_o = val_q;

  p_capture_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> cap_val_o == $past(cnt_i));
  p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q.flag_en) |=> flag_o);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !set_ev) |=> !flag_o);
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q.toggle_en) |=> tog_q != $past(tog_q));
  p_cmp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.cmp_en |=> $stable(tog_q));
endmodule

// File: tb/ccm_channel_tb_top.sv
module ccm_channel_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        cap_pin = 1'b0;
  logic        mode_we = 1'b0;
  logic [6:0]  mode_wdata = '0;
  logic        val_we = 1'b0;
  logic [15:0] val_wdata = '0;
  logic        flag_clr = 1'b0;
  logic        pin_o, flag_o, irq_o;
  logic [15:0] cap_val_o;

  ccm_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cap_pin_i(cap_pin),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .val_we_i(val_we), .val_wdata_i(val_wdata), .flag_clr_i(flag_clr),
    .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o), .cap_val_o(cap_val_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    step = 0;
  string phase = "R1";

  // Behavioural reference model, updated on each rising edge.
  logic [6:0]  m_mode;
  logic [15:0] m_val, m_prev;
  logic        m_flag, m_tog, m_pwm, m_s1, m_s2, m_s3;
  logic        m_rise, m_fall, m_cap, m_hit, m_wrap;
  logic [15:0] m_old;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = '0; m_val = '0; m_prev = '0; m_flag = 0; m_tog = 0;
      m_pwm = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      m_old  = m_val;
      m_rise = m_s2 && !m_s3;
      m_fall = !m_s2 && m_s3;
      m_cap  = (m_rise && m_mode[5]) || (m_fall && m_mode[4]);
      m_hit  = m_mode[6] && (cnt == m_old) && (cnt != m_prev);
      m_wrap = m_mode[1] && (m_prev[7:0] == 8'hFF) && (cnt[7:0] == 8'h00);
      if (m_cap) m_val = cnt;
      else if (val_we) m_val = val_wdata;
      else if (m_wrap) m_val[7:0] = m_old[15:8];
      if (m_cap || (m_hit && m_mode[3])) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (m_hit && m_mode[2]) m_tog = !m_tog;
      m_pwm = m_mode[1] && (cnt[7:0] >= m_old[7:0]);
      if (mode_we) m_mode = mode_wdata;
      m_prev = cnt;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Model comparison on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(phase, "model pin", {15'd0, pin_o}, {15'd0, m_mode[1] ? m_pwm : m_tog});
      check(phase, "model flag", {15'd0, flag_o}, {15'd0, m_flag});
      check(phase, "model irq", {15'd0, irq_o}, {15'd0, m_flag & m_mode[0]});
      check(phase, "model value", cap_val_o, m_val);
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      cnt = cnt + 16'(step);
    end
  endtask

  task automatic set_mode(logic [6:0] v);
    @(negedge clk); mode_we = 1; mode_wdata = v;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic write_val(logic [15:0] v);
    @(negedge clk); val_we = 1; val_wdata = v;
    @(negedge clk); val_we = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic p0;
    int   hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1", "pin", {15'd0, pin_o}, 16'd0);
    check("R1", "flag", {15'd0, flag_o}, 16'd0);
    check("R1", "irq", {15'd0, irq_o}, 16'd0);
    check("R1", "value", cap_val_o, 16'd0);

    // R2: rising-edge capture with two-flop delay
    phase = "R2";
    step = 0; cnt = 16'h1234;
    set_mode(7'h20);
    @(negedge clk); cap_pin = 1;
    tick(2);
    check("R2", "flag before capture", {15'd0, flag_o}, 16'd0);
    tick(1);
    check("R2", "captured value", cap_val_o, 16'h1234);
    check("R2", "flag after capture", {15'd0, flag_o}, 16'd1);

    // R10: plain clear
    phase = "R10";
    clear_flag();
    check("R10", "flag cleared", {15'd0, flag_o}, 16'd0);

    // R3: falling edge, then both edges
    phase = "R3";
    set_mode(7'h10);
    cnt = 16'h0555;
    @(negedge clk); cap_pin = 0;
    tick(3);
    check("R3", "fall capture", cap_val_o, 16'h0555);
    check("R3", "fall flag", {15'd0, flag_o}, 16'd1);
    set_mode(7'h30);
    clear_flag();
    cnt = 16'h0777;
    @(negedge clk); cap_pin = 1;
    tick(3);
    check("R3", "both-edge rise capture", cap_val_o, 16'h0777);
    cnt = 16'h0888;
    @(negedge clk); cap_pin = 0;
    tick(3);
    check("R3", "both-edge fall capture", cap_val_o, 16'h0888);

    // R11: capture beats a same-cycle write
    phase = "R11";
    set_mode(7'h20);
    cnt = 16'h0999;
    @(negedge clk); cap_pin = 1;
    tick(2);
    val_we = 1; val_wdata = 16'hBEEF;
    @(negedge clk); val_we = 0;
    check("R11", "capture wins", cap_val_o, 16'h0999);
    write_val(16'h0010);
    check("R11", "plain write", cap_val_o, 16'h0010);

    // R4: comparator disabled
    phase = "R4";
    set_mode(7'h0C);
    clear_flag();
    p0 = pin_o;
    cnt = 16'h000C; step = 1;
    tick(8);
    check("R4", "no flag without compare", {15'd0, flag_o}, 16'd0);
    check("R4", "no toggle without compare", {15'd0, pin_o}, {15'd0, p0});

    // R5: flag enable gating
    phase = "R5";
    step = 0; set_mode(7'h40);
    cnt = 16'h000C; step = 1;
    tick(8);
    check("R5", "no flag with flag bit clear", {15'd0, flag_o}, 16'd0);
    step = 0; set_mode(7'h48);
    cnt = 16'h000C; step = 1;
    tick(8);
    check("R5", "match sets flag", {15'd0, flag_o}, 16'd1);

    // R9: interrupt gating
    phase = "R9";
    step = 0;
    check("R9", "irq masked", {15'd0, irq_o}, 16'd0);
    set_mode(7'h49);
    check("R9", "irq raised", {15'd0, irq_o}, 16'd1);

    // R10: match in the same cycle as clear wins
    phase = "R10";
    set_mode(7'h48);
    clear_flag();
    check("R10", "flag cleared before race", {15'd0, flag_o}, 16'd0);
    cnt = 16'h000F;
    @(negedge clk); cnt = 16'h0010; flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    check("R10", "set wins over clear", {15'd0, flag_o}, 16'd1);

    // R6: toggle on each match
    phase = "R6";
    set_mode(7'h44);
    p0 = pin_o;
    cnt = 16'h000C; step = 1;
    tick(8);
    check("R6", "first toggle", {15'd0, pin_o}, {15'd0, ~p0});
    step = 0; cnt = 16'h000C; step = 1;
    tick(8);
    check("R6", "second toggle", {15'd0, pin_o}, {15'd0, p0});

    // R7: stalled count toggles once
    phase = "R7";
    step = 0;
    cnt = 16'h000F;
    @(negedge clk);
    p0 = pin_o;
    cnt = 16'h0010;
    tick(6);
    check("R7", "single event on stall", {15'd0, pin_o}, {15'd0, ~p0});

    // R8: PWM duty and reload on wrap
    phase = "R8";
    write_val(16'h4040);
    set_mode(7'h02);
    cnt = 16'h00F0; step = 1;
    tick(40);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      tick(1);
      if (pin_o) hi++;
    end
    check("R8", "duty at 0x40", 16'(hi), 16'd192);
    step = 0;
    write_val(16'h8040);
    check("R8", "low byte kept until wrap", cap_val_o, 16'h8040);
    step = 1;
    tick(300);
    check("R8", "low byte reloaded", cap_val_o, 16'h8080);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      tick(1);
      if (pin_o) hi++;
    end
    check("R8", "duty at 0x80", 16'(hi), 16'd128);

    finish_run();
  end
endmodule